// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

This block is a synchronous 1024-byte memory with two independent ports, left and right. Each port has its own active-low chip enable, output enable and read/write strobe, a 10-bit address, a write-data bus and a registered read-data bus. Either port may read or write any location in any cycle.

The two highest locations double as doorbells between the ports. A left write to the top location raises the right port's active-low interrupt. A right write to the location below it raises the left port's interrupt. A port drops its own interrupt by reading its own doorbell location. The bytes stored there remain ordinary memory and carry whatever message software places in them.

Each port also has an active-low write-inhibit input, driven by an external contention arbiter. While a port's inhibit is low, that port cannot change the array or any interrupt flag.

Top module: `dpram_mailbox`

## Requirements
- R1: While reset is low and on the first cycle after it, both interrupt outputs are high and both read-data outputs are zero.
- R2: A port writes its write data to its address at the rising edge when its chip enable and read/write are both low and its inhibit is high. A read happens when chip enable and output enable are low and read/write is high: the byte is on that port's read data after the next rising edge. In all other cycles, the read data is zero after that edge.
- R3: A left write to address 0x3FF drives the right interrupt low after that edge, provided the left inhibit is high.
- R4: A right access to 0x3FF with chip enable and output enable both low returns the right interrupt high after that edge, whatever the read/write level, provided the right inhibit is high.
- R5: A right write to 0x3FE drives the left interrupt low. A left access to 0x3FE with chip enable and output enable low, and the left inhibit high, returns it high.
- R6: The bytes at 0x3FE and 0x3FF are written and read back like any other location.
- R7: A write from a port whose inhibit is low leaves the array unchanged.
- R8: An action from a port whose inhibit is low does not change an interrupt flag, whether that action would set the flag or clear it.
- R9: When a flag is set and cleared in the same cycle, the set wins and the interrupt goes low.
- R10: When one port reads an address that the other port writes in the same cycle, the reading port returns the old byte.
- R11: When both ports write the same address in the same cycle, the left port's byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rw_n | input | 1 | Left read (1) / write (0) |
| l_blk_n | input | 1 | Left write inhibit, active low |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rw_n | input | 1 | Right read (1) / write (0) |
| r_blk_n | input | 1 | Right write inhibit, active low |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Each result of this block appears after exactly one rising edge. Read data, interrupt set, interrupt clear and array update all take effect at the edge that samples the request. The bench applies each stimulus just after a falling edge and compares all four outputs at the next falling edge against a bench model advanced by one step. A write is confirmed by a read in a later cycle. A same-cycle collision is confirmed by comparing the colliding read with the byte held before the edge.

// File: rtl/dpmb_pkg.sv
// Shared types for the dual-port mailbox memory.
// Assumes: decoders and top agree on this action record.
package dpmb_pkg;
    // Per-port decoded action for one cycle
    typedef struct packed {
        logic wr;     // write to the array (inhibit already applied)
        logic rd;     // read into the registered output
        logic ring;   // write to the opposite port's doorbell
        logic ack;    // access to own doorbell that clears own flag
    } port_act_t;
endpackage

// File: rtl/dpmb_port_dec.sv
// Decodes one port's strobes into array and doorbell actions.
// Assumes: strobes are active low. An inhibit blocks both the write and the flag actions.
module dpmb_port_dec
    import dpmb_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int OWN_BELL  = 1022,
    parameter int PEER_BELL = 1023
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              rw_n,
    input  logic              blk_n,
    input  logic [ADDR_W-1:0] addr,
    output port_act_t         act
);
    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BELL);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BELL);

    // Combine strobes, inhibit and address match into one action record
    always_comb begin
        act.wr   = !ce_n && !rw_n && blk_n;
        act.rd   = !ce_n && !oe_n && rw_n;
        act.ring = act.wr && (addr == PEER_A);
        act.ack  = !ce_n && !oe_n && blk_n && (addr == OWN_A);
    end
endmodule

// File: rtl/dpmb_irq_flag.sv
// One active-low doorbell interrupt flag. A set beats a simultaneous clear.
// Assumes: set and clear arrive already qualified by the acting port's inhibit.
module dpmb_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    // Hold the flag state; reset makes it inactive (high)
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_n_o <= 1'b1;
        else if (set_i) irq_n_o <= 1'b0;
        else if (clr_i) irq_n_o <= 1'b1;
    end

    // R1
    irq_rst_chk: assert property (@(posedge clk) !rst_n |=> irq_n_o);
    // R3 R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> !irq_n_o);
    // R4
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !set_i) |=> irq_n_o);
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!set_i && !clr_i) |=> $stable(irq_n_o));
endmodule

// File: rtl/dpmb_mem.sv
// Two-port storage array with registered reads.
// Assumes: a read sees the contents from before the same edge's writes.
// Port A (left) wins a same-address write collision.
module dpmb_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Array update; A is written last so it wins an address collision
    always_ff @(posedge clk) begin
        if (b_wr) store[b_addr] <= b_wdata;
        if (a_wr) store[a_addr] <= a_wdata;
    end

    // Registered read outputs, zero when no read is requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            a_rdata <= a_rd ? store[a_addr] : '0;
            b_rdata <= b_rd ? store[b_addr] : '0;
        end
    end

    // R2
    rd_idle_a_chk: assert property (@(posedge clk) disable iff (!rst_n) !a_rd |=> (a_rdata == '0));
    // R2
    rd_idle_b_chk: assert property (@(posedge clk) disable iff (!rst_n) !b_rd |=> (b_rdata == '0));
endmodule

// File: rtl/dpram_mailbox.sv
// Dual-port memory with doorbell interrupts at the two top addresses.
// The left doorbell is DEPTH-2 and the right doorbell is DEPTH-1.
// Assumes: the write inhibits come from an external arbiter and are synchronous to clk.
module dpram_mailbox
    import dpmb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_rw_n,
    input  logic              l_blk_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_rw_n,
    input  logic              r_blk_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int L_BELL = DEPTH - 2;
    localparam int R_BELL = DEPTH - 1;

    port_act_t l_act, r_act;

    dpmb_port_dec #(.ADDR_W(ADDR_W), .OWN_BELL(L_BELL), .PEER_BELL(R_BELL)) u_l_dec (
        .ce_n(l_ce_n), .oe_n(l_oe_n), .rw_n(l_rw_n), .blk_n(l_blk_n),
        .addr(l_addr), .act(l_act)
    );

    dpmb_port_dec #(.ADDR_W(ADDR_W), .OWN_BELL(R_BELL), .PEER_BELL(L_BELL)) u_r_dec (
        .ce_n(r_ce_n), .oe_n(r_oe_n), .rw_n(r_rw_n), .blk_n(r_blk_n),
        .addr(r_addr), .act(r_act)
    );

    dpmb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .a_wr(l_act.wr), .a_rd(l_act.rd), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_rdata),
        .b_wr(r_act.wr), .b_rd(r_act.rd), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_rdata)
    );

    // Left flag: rung by the right port, acknowledged by the left port
    dpmb_irq_flag u_l_irq (
        .clk(clk), .rst_n(rst_n), .set_i(r_act.ring), .clr_i(l_act.ack), .irq_n_o(l_irq_n)
    );

    // Right flag: rung by the left port, acknowledged by the right port
    dpmb_irq_flag u_r_irq (
        .clk(clk), .rst_n(rst_n), .set_i(l_act.ring), .clr_i(r_act.ack), .irq_n_o(r_irq_n)
    );

    // R8
    blk_r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_blk_n && !r_blk_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/dpram_mailbox_tb.sv
`timescale 1ns/1ps
module dpram_mailbox_tb_top;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] LB = 10'h3FE;
    localparam logic [AW-1:0] RB = 10'h3FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_ce_n = 1'b1, l_oe_n = 1'b1, l_rw_n = 1'b1, l_blk_n = 1'b1;
    logic r_ce_n = 1'b1, r_oe_n = 1'b1, r_rw_n = 1'b1, r_blk_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    always #4 clk = ~clk;

    dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_rw_n(l_rw_n), .l_blk_n(l_blk_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_rw_n(r_rw_n), .r_blk_n(r_blk_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    int chk_cnt = 0;
    int fail_cnt = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [DEPTH];
    logic m_lirq = 1'b1, m_rirq = 1'b1;
    logic [DW-1:0] e_lr = '0, e_rr = '0;

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
            $finish;
        end
    endtask

    task automatic idle();
        l_ce_n = 1; l_oe_n = 1; l_rw_n = 1; l_blk_n = 1;
        r_ce_n = 1; r_oe_n = 1; r_rw_n = 1; r_blk_n = 1;
    endtask

    task automatic set_l(input logic ce, input logic oe, input logic rw, input logic blk,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_ce_n = ce; l_oe_n = oe; l_rw_n = rw; l_blk_n = blk; l_addr = a; l_wdata = d;
    endtask

    task automatic set_r(input logic ce, input logic oe, input logic rw, input logic blk,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_ce_n = ce; r_oe_n = oe; r_rw_n = rw; r_blk_n = blk; r_addr = a; r_wdata = d;
    endtask

    // Advance the model by one edge from the current inputs, then compare at the next falling edge
    task automatic tick(input string tag);
        logic lw, lrd, rw, rrd, setr, clrr, setl, clrl;
        lw   = !l_ce_n && !l_rw_n && l_blk_n;
        lrd  = !l_ce_n && !l_oe_n && l_rw_n;
        rw   = !r_ce_n && !r_rw_n && r_blk_n;
        rrd  = !r_ce_n && !r_oe_n && r_rw_n;
        setr = lw && (l_addr == RB);
        clrr = !r_ce_n && !r_oe_n && r_blk_n && (r_addr == RB);
        setl = rw && (r_addr == LB);
        clrl = !l_ce_n && !l_oe_n && l_blk_n && (l_addr == LB);
        if (!rst_n) begin
            e_lr = '0; e_rr = '0; m_lirq = 1; m_rirq = 1;
        end else begin
            e_lr = lrd ? model[l_addr] : '0;
            e_rr = rrd ? model[r_addr] : '0;
            if (setr) m_rirq = 0; else if (clrr) m_rirq = 1;
            if (setl) m_lirq = 0; else if (clrl) m_lirq = 1;
        end
        if (rw) model[r_addr] = r_wdata;
        if (lw) model[l_addr] = l_wdata;
        @(negedge clk);
        chk(tag, "l_rdata", l_rdata, e_lr);
        chk(tag, "r_rdata", r_rdata, e_rr);
        chk(tag, "l_irq_n", {7'd0, l_irq_n}, {7'd0, m_lirq});
        chk(tag, "r_irq_n", {7'd0, r_irq_n}, {7'd0, m_rirq});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        int seed;
        seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        idle();
        // R1: outputs during and right after reset
        tick("R1");
        tick("R1");
        rst_n = 1;
        tick("R1");
        // Preload every location through the left port (R2)
        for (int i = 0; i < DEPTH; i++) begin
            set_l(0, 1, 0, 1, AW'(i), DW'(i * 7 + 3));
            tick("R2");
        end
        idle();
        rst_n = 0; tick("R1");
        rst_n = 1; tick("R1");
        // R2: write then read on the right port
        set_r(0, 1, 0, 1, 10'h055, 8'hA5); tick("R2");
        set_r(0, 0, 1, 1, 10'h055, 8'h00); tick("R2");
        // R2: output enable high yields zero read data
        set_r(0, 1, 1, 1, 10'h055, 8'h00); tick("R2");
        idle();
        // R3 and R6: left rings the right doorbell with a message
        set_l(0, 1, 0, 1, RB, 8'h3C); tick("R3");
        idle(); tick("R3");
        // R4: right clears with read/write low (it also writes its own doorbell)
        set_r(0, 0, 0, 1, RB, 8'h77); tick("R4");
        idle();
        // R6: message readable by the left port
        set_l(0, 0, 1, 1, RB, 8'h00); tick("R6");
        // R5: right rings left, left reads to clear
        set_r(0, 1, 0, 1, LB, 8'hC3); idle_l(); tick("R5");
        set_l(0, 0, 1, 1, LB, 8'h00); r_ce_n = 1; tick("R5");
        idle();
        // R7: inhibited write leaves the array unchanged
        set_l(0, 1, 0, 0, 10'h055, 8'hFF); tick("R7");
        set_l(0, 0, 1, 1, 10'h055, 8'h00); tick("R7");
        idle();
        // R8: inhibited ring does nothing; inhibited clear does nothing
        set_l(0, 1, 0, 0, RB, 8'h11); tick("R8");
        set_l(0, 1, 0, 1, RB, 8'h22); tick("R8");
        set_l(1, 1, 1, 1, 10'h0, 8'h0); set_r(0, 0, 1, 0, RB, 8'h0); tick("R8");
        idle(); tick("R8");
        // R9: ring and clear of the right flag in the same cycle
        set_l(0, 1, 0, 1, RB, 8'h44); set_r(0, 0, 1, 1, RB, 8'h00); tick("R9");
        idle(); tick("R9");
        set_r(0, 0, 1, 1, RB, 8'h00); tick("R4");
        idle();
        // R10: right reads while left writes the same address
        set_l(0, 1, 0, 1, 10'h123, 8'h9E); set_r(0, 0, 1, 1, 10'h123, 8'h00); tick("R10");
        idle();
        set_r(0, 0, 1, 1, 10'h123, 8'h00); tick("R10");
        idle();
        // R11: both write the same address
        set_l(0, 1, 0, 1, 10'h200, 8'h5A); set_r(0, 1, 0, 1, 10'h200, 8'hA5); tick("R11");
        idle();
        set_l(0, 0, 1, 1, 10'h200, 8'h00); tick("R11");
        idle();
        // Random mix, addresses biased toward doorbells and collisions
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] al, ar;
            al = ($urandom % 4 == 0) ? (($urandom % 2) ? RB : LB) : AW'($urandom % 8);
            ar = ($urandom % 4 == 0) ? (($urandom % 2) ? RB : LB) : AW'($urandom % 8);
            set_l(($urandom % 5) == 0, $urandom % 2, $urandom % 2, ($urandom % 8) != 0, al, DW'($urandom));
            set_r(($urandom % 5) == 0, $urandom % 2, $urandom % 2, ($urandom % 8) != 0, ar, DW'($urandom));
            tick("R2 R3 R4 R5 R10");
        end
        idle();
        tick("R2");
        finish_run();
    end

    task automatic idle_l();
        l_ce_n = 1; l_oe_n = 1; l_rw_n = 1; l_blk_n = 1;
    endtask
endmodule